// File: doc/BRIEF.md
# Integer Condition Flag Unit

This block derives the five condition flags of an integer datapath from one finished operation. The flags are extend (X), negative (N), zero (Z), overflow (V) and carry/borrow (C). The datapath supplies the source operand, the destination operand, the result its ALU produced, an operation class and an operand size. On a valid strobe the unit evaluates the sign and zero equations on the sized operands and loads the outcome into a 5-bit flag register. Without the strobe the register keeps its value.

The extend flag is kept apart from the carry flag. A chain of multi-word additions or subtractions can then pass its carry through X while C stays free for branch decisions. The two extended classes also treat Z as sticky: a nonzero partial result clears Z, and a zero partial result leaves it alone. After the last word of a chain, Z is set only if every word was zero, provided software set Z before the chain began.

Top module: `ccg_unit`

## Requirements
- R1: While reset is asserted, and at the first sampling after it is released, `flags_o` reads 5'b00000. The bit order is X=bit4, N=bit3, Z=bit2, V=bit1, C=bit0.
- R2: When `valid_i` is low at a rising clock edge, `flags_o` keeps its previous value, whatever the other inputs carry.
- R3: For add (op 0) and add-with-extend (op 1), C = S·D + ~R·D + S·~R and V = S·D·~R + ~S·~D·R. S, D and R are the sized most-significant bits of source, destination and result.
- R4: For subtract (op 2) and subtract-with-extend (op 3), where the result is destination minus source, C = S·~D + R·~D + S·R and V = ~S·D·~R + S·~D·R.
- R5: For ops 0 to 3, X takes the newly computed C and N takes R. For ops 0 and 2, Z is set exactly when the sized result is zero.
- R6: For ops 1 and 3, Z becomes the previous Z ANDed with "sized result is zero". A nonzero result clears Z, and a zero result leaves Z unchanged.
- R7: For the logical/move/test class (op 4), V and C become 0, N takes R, Z is set exactly when the sized result is zero, and X is unchanged.
- R8: For clear (op 5), N=0, Z=1, V=0 and C=0 regardless of the operands, and X is unchanged.
- R9: Size code 0 is byte (most-significant bit 7, zero test on bits 7:0), code 1 is word (bit 15, bits 15:0) and code 2 is long (bit 31, bits 31:0). Bits above the selected size have no effect on any flag.
- R10: A valid strobe carrying a reserved op code (6 or 7) or the reserved size code 3 leaves `flags_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Load the flags evaluated from this cycle's inputs |
| op_i | input | 3 | Operation class: 0 add, 1 add-with-extend, 2 subtract, 3 subtract-with-extend, 4 logical/move/test, 5 clear |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| src_i | input | DATA_W | Source operand |
| dst_i | input | DATA_W | Destination operand |
| res_i | input | DATA_W | Result produced by the datapath |
| flags_o | output | 5 | Registered flags {X, N, Z, V, C} |

## Verification
The most delicate overlap is the extended-precision class. In a single cycle it writes a freshly computed carry into both X and C and, through the sticky rule, merges the previous Z with the current zero test. The bench provokes this with chains of op 1 and op 3 whose partial results alternate between zero and nonzero, starting from Z both set and cleared. In each cycle it checks that X equals the new C while Z follows only the AND rule. Random sequences mix all classes with garbage in the upper operand bits. That mix exposes any Z or X leaking across classes or sizes, and every cycle is judged against a bench model built from the requirement equations.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

   localparam int unsigned CCG_NUM_SIZES = 3;
   localparam int unsigned CCG_FLAG_W    = 5;

   typedef enum logic [2:0] {
      OP_ADD   = 3'd0,
      OP_ADDX  = 3'd1,
      OP_SUB   = 3'd2,
      OP_SUBX  = 3'd3,
      OP_LOGIC = 3'd4,
      OP_CLR   = 3'd5
   } ccg_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2
   } ccg_size_e;

   typedef struct packed {
      logic x;
      logic n;
      logic z;
      logic v;
      logic c;
   } ccg_flags_t;

   // Sign-bit summary of one sized operation
   typedef struct packed {
      logic s_msb;
      logic d_msb;
      logic r_msb;
      logic r_zero;
   } ccg_view_t;

endpackage

// File: rtl/ccg_sized_view.sv
module ccg_sized_view
   import ccg_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [1:0]        size_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] res_i,
   output ccg_view_t         view_o,
   output logic              size_ok_o
);

   localparam int unsigned LANE_BASE = 8;
   localparam int unsigned MAX_LANE  = LANE_BASE << (CCG_NUM_SIZES - 1);

   if (DATA_W < MAX_LANE) begin : g_bad_width
      $error("ccg_sized_view: DATA_W must cover the widest size");
   end

   ccg_view_t lane_view [CCG_NUM_SIZES];

   // One lane per supported size: byte, word, long
   for (genvar li = 0; li < CCG_NUM_SIZES; li++) begin : g_lane
      localparam int unsigned LW = LANE_BASE << li;
      assign lane_view[li].s_msb  = src_i[LW-1];
      assign lane_view[li].d_msb  = dst_i[LW-1];
      assign lane_view[li].r_msb  = res_i[LW-1];
      assign lane_view[li].r_zero = ~|res_i[LW-1:0];
   end

   always_comb begin
      size_ok_o = 1'b1;
      view_o    = '0;
      unique case (size_i)
         SZ_BYTE: view_o = lane_view[0];
         SZ_WORD: view_o = lane_view[1];
         SZ_LONG: view_o = lane_view[2];
         default: size_ok_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/ccg_flag_eq.sv
module ccg_flag_eq
   import ccg_pkg::*;
(
   input  logic [2:0] op_i,
   input  ccg_view_t  view_i,
   input  ccg_flags_t prev_i,
   output ccg_flags_t next_o,
   output logic       op_ok_o
);

   logic s, d, r;
   logic c_add, v_add, c_sub, v_sub;
   logic z_plain, z_sticky;

   assign s = view_i.s_msb;
   assign d = view_i.d_msb;
   assign r = view_i.r_msb;

   // Carry and overflow of an addition from the sign bits
   assign c_add = (s & d) | (~r & d) | (s & ~r);
   assign v_add = (s & d & ~r) | (~s & ~d & r);

   // Borrow and overflow of destination minus source
   assign c_sub = (s & ~d) | (r & ~d) | (s & r);
   assign v_sub = (~s & d & ~r) | (s & ~d & r);

   assign z_plain  = view_i.r_zero;
   assign z_sticky = prev_i.z & view_i.r_zero;

   always_comb begin
      next_o  = prev_i;
      op_ok_o = 1'b1;
      unique case (op_i)
         OP_ADD, OP_ADDX: begin
            next_o.c = c_add;
            next_o.x = c_add;
            next_o.v = v_add;
            next_o.n = r;
            next_o.z = (op_i == OP_ADDX) ? z_sticky : z_plain;
         end
         OP_SUB, OP_SUBX: begin
            next_o.c = c_sub;
            next_o.x = c_sub;
            next_o.v = v_sub;
            next_o.n = r;
            next_o.z = (op_i == OP_SUBX) ? z_sticky : z_plain;
         end
         OP_LOGIC: begin
            next_o.c = 1'b0;
            next_o.v = 1'b0;
            next_o.n = r;
            next_o.z = z_plain;
         end
         OP_CLR: begin
            next_o.c = 1'b0;
            next_o.v = 1'b0;
            next_o.n = 1'b0;
            next_o.z = 1'b1;
         end
         default: op_ok_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/ccg_flag_reg.sv
module ccg_flag_reg
   import ccg_pkg::*;
#(
   parameter ccg_flags_t RESET_VAL = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  ccg_flags_t d_i,
   output ccg_flags_t q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= RESET_VAL;
      end else if (load_i) begin
         q_o <= d_i;
      end
   end

endmodule

// File: rtl/ccg_unit.sv
module ccg_unit
   import ccg_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [2:0]        op_i,
   input  logic [1:0]        size_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] res_i,
   output logic [4:0]        flags_o
);

   if (CCG_FLAG_W != 5) begin : g_bad_flags
      $error("ccg_unit: flag register must be five bits");
   end

   ccg_view_t  view;
   ccg_flags_t flags_q;
   ccg_flags_t flags_nx;
   logic       size_ok;
   logic       op_ok;
   logic       load;

   ccg_sized_view #(
      .DATA_W (DATA_W)
   ) u_view (
      .size_i    (size_i),
      .src_i     (src_i),
      .dst_i     (dst_i),
      .res_i     (res_i),
      .view_o    (view),
      .size_ok_o (size_ok)
   );

   ccg_flag_eq u_eq (
      .op_i    (op_i),
      .view_i  (view),
      .prev_i  (flags_q),
      .next_o  (flags_nx),
      .op_ok_o (op_ok)
   );

   assign load = valid_i & size_ok & op_ok;

   ccg_flag_reg #(
      .RESET_VAL ('0)
   ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .d_i    (flags_nx),
      .q_o    (flags_q)
   );

   assign flags_o = flags_q;

endmodule

// File: rtl/ccg_unit_chk.sv
module ccg_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       valid_i,
   input logic [2:0] op_i,
   input logic [1:0] size_i,
   input logic [4:0] flags_o
);

   logic legal_size;
   assign legal_size = (size_i != 2'd3);

   // R2
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(flags_o));

   // R10
   reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (op_i > 3'd5 || !legal_size)) |=> $stable(flags_o));

   // R5
   extend_tracks_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && legal_size && op_i <= 3'd3) |=> (flags_o[4] == flags_o[0]));

   // R6
   sticky_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && legal_size && (op_i == 3'd1 || op_i == 3'd3) && !flags_o[2])
      |=> !flags_o[2]);

   // R7
   logic_clears_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && legal_size && op_i == 3'd4)
      |=> (flags_o[1:0] == 2'b00 && flags_o[4] == $past(flags_o[4])));

   // R8
   clear_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && legal_size && op_i == 3'd5)
      |=> (flags_o[3:0] == 4'b0100 && flags_o[4] == $past(flags_o[4])));

endmodule

bind ccg_unit ccg_unit_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .valid_i (valid_i),
   .op_i    (op_i),
   .size_i  (size_i),
   .flags_o (flags_o)
);

// File: tb/ccg_unit_tb.sv
`timescale 1ns/1ps
module ccg_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [2:0]  op_i = '0;
   logic [1:0]  size_i = '0;
   logic [31:0] src_i = '0, dst_i = '0, res_i = '0;
   logic [4:0]  flags_o;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   logic [4:0] model_q = '0;

   always #10 clk = ~clk;

   ccg_unit #(.DATA_W(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
      .size_i(size_i), .src_i(src_i), .dst_i(dst_i), .res_i(res_i),
      .flags_o(flags_o)
   );

   // Reference flags from the requirement equations (R3..R10)
   function automatic logic [4:0] ref_flags(logic [4:0] p, logic v, logic [2:0] op,
                                            logic [1:0] sz, logic [31:0] s,
                                            logic [31:0] d, logic [31:0] r);
      int w;
      logic sm, dm, rm, zr, c, ov;
      logic [4:0] n;
      if (!v || op > 3'd5 || sz == 2'd3) return p;
      w  = 8 << sz;
      sm = s[w-1]; dm = d[w-1]; rm = r[w-1];
      zr = ((r << (32 - w)) == 32'd0);
      n  = p;
      if (op <= 3'd1) begin
         c  = (sm & dm) | (~rm & dm) | (sm & ~rm);
         ov = (sm & dm & ~rm) | (~sm & ~dm & rm);
      end else begin
         c  = (sm & ~dm) | (rm & ~dm) | (sm & rm);
         ov = (~sm & dm & ~rm) | (sm & ~dm & rm);
      end
      case (op)
         3'd0, 3'd2: n = {c, rm, zr, ov, c};
         3'd1, 3'd3: n = {c, rm, p[2] & zr, ov, c};
         3'd4:       n = {p[4], rm, zr, 1'b0, 1'b0};
         default:    n = {p[4], 4'b0100};
      endcase
      return n;
   endfunction

   function automatic string tag_of(logic v, logic [2:0] op, logic [1:0] sz);
      if (!v) return "R2";
      if (op > 3'd5 || sz == 2'd3) return "R10";
      case (op)
         3'd0: return "R3";
         3'd1: return "R6";
         3'd2: return "R4";
         3'd3: return "R6";
         3'd4: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(logic [4:0] exp, string tag);
      checks++;
      if (flags_o !== exp) begin
         errors++;
         $display("FAIL %s: flags=%b expected %b", tag, flags_o, exp);
      end
   endtask

   // Drive at negedge, the register loads at posedge, sample at next negedge
   task automatic step(logic v, logic [2:0] op, logic [1:0] sz,
                       logic [31:0] s, logic [31:0] d, logic [31:0] r, string tag);
      logic [4:0] exp;
      valid_i = v; op_i = op; size_i = sz; src_i = s; dst_i = d; res_i = r;
      exp = ref_flags(model_q, v, op, sz, s, d, r);
      @(posedge clk);
      @(negedge clk);
      check(exp, tag);
      model_q = exp;
      valid_i = 1'b0;
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: flags=%b expected completion", flags_o);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      repeat (3) @(negedge clk);
      check(5'b00000, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      check(5'b00000, "R1");

      // R3 byte signed overflow, upper bits garbage (R9)
      step(1, 3'd0, 2'd0, 32'hABCD_0001, 32'h1234_567F, 32'h5555_0080, "R3");
      check(5'b01010, "R3");
      // R9 byte carry out to zero with nonzero upper bits; X mirrors C (R5)
      step(1, 3'd0, 2'd0, 32'hFFFF_FF01, 32'h0000_00FF, 32'hFFFF_FF00, "R9");
      check(5'b10101, "R9");
      // R4 word borrow 0 - 1
      step(1, 3'd2, 2'd1, 32'h0000_0001, 32'hAAAA_0000, 32'h0000_FFFF, "R4");
      check(5'b11001, "R4");
      // R4 long signed overflow
      step(1, 3'd2, 2'd2, 32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF, "R4");
      check(5'b00010, "R4");
      // R7 X kept after a logic op: first set X with a carry
      step(1, 3'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, "R5");
      step(1, 3'd4, 2'd1, 32'h0, 32'h0, 32'h1234_8000, "R7");
      check(5'b11000, "R7");
      // R8 clear ignores a nonzero result
      step(1, 3'd5, 2'd2, 32'hFFFF_FFFF, 32'h1, 32'hFFFF_FFFF, "R8");
      check(5'b10100, "R8");
      // R6 sticky chain: Z set, zero keeps, nonzero clears, zero does not restore
      step(1, 3'd1, 2'd1, 32'h0, 32'h0, 32'h0001_0000, "R6");
      check(5'b00100, "R6");
      step(1, 3'd3, 2'd0, 32'h0, 32'h1, 32'h0000_0001, "R6");
      check(5'b00000, "R6");
      step(1, 3'd1, 2'd0, 32'h0, 32'h0, 32'h0000_0000, "R6");
      check(5'b00000, "R6");
      // R10 reserved codes and R2 idle hold
      step(1, 3'd6, 2'd2, 32'hF, 32'hF, 32'h0, "R10");
      step(1, 3'd2, 2'd3, 32'hF, 32'h0, 32'h0, "R10");
      step(0, 3'd5, 2'd0, 32'h0, 32'h0, 32'h0, "R2");

      for (int i = 0; i < 600; i++) begin
         logic [2:0]  op  = 3'($urandom % 8);
         logic [1:0]  sz  = 2'($urandom % 4);
         logic        v   = ($urandom % 8) != 0;
         logic [31:0] s   = $urandom;
         logic [31:0] d   = $urandom;
         logic [31:0] r;
         int          pick = int'($urandom % 4);
         if (pick == 0)      r = d + s + {31'd0, model_q[4]};
         else if (pick == 1) r = d - s - {31'd0, model_q[4]};
         else if (pick == 2) r = $urandom & 32'hFFFF_FF00;
         else                r = $urandom;
         step(v, op, sz, s, d, r, tag_of(v, op, sz));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule